// File: doc/BRIEF.md
# Speculative One-Tap Decision Feedback Equalizer

This block turns a stream of signed, already-digitised samples into hard bit decisions while cancelling one symbol of trailing inter-symbol interference. It takes one sample per bit. No arithmetic sits inside the decision loop. Two comparators work on each sample at the same time. One compares it against a threshold raised by the tap weight, for the case where the previous bit was 1. The other compares it against a threshold lowered by the same amount, for the case where the previous bit was 0. The registered previous decision then picks one of the two tentative answers. The loop therefore holds only a 2:1 selector and a single flip-flop.

The tap weight comes from outside the block, for example from an adaptation engine, and the block never changes it. A weight of zero turns the block into a plain sign slicer. A weight equal to the trailing interference level of the channel removes that interference from the decision, even when the interference is larger than the wanted signal.

Top module: `spec_dfe1`

## Requirements
- R1: When the registered previous decision is 1, the new decision is 1 exactly when the sample is strictly greater than the tap weight, with both read as two's-complement signed values.
- R2: When the registered previous decision is 0, the new decision is 1 exactly when the sample is strictly greater than the negated tap weight. The negation is exact for every weight, so a weight of -128 at 8 bits gives a threshold of +128.
- R3: The choice between the two tentative results is made only by the block's own last registered decision (`dec_o`), so the same sample and weight can give different decisions depending on the bit before.
- R4: A sample presented with `smp_vld_i` high at a rising edge produces its decision on `dec_o` after that edge, with `dec_vld_o` high for exactly that one cycle.
- R5: While `rst` is high at a rising edge, `dec_o` and `dec_vld_o` are both driven to 0 after that edge. This holds whether reset comes at start-up or in the middle of a stream.
- R6: A rising edge with `smp_vld_i` low leaves `dec_o` unchanged and drives `dec_vld_o` low, whatever values `smp_i` and `tap_w_i` carry.
- R7: With a tap weight of 0 the block acts as a sign slicer: a positive sample gives 1, and a zero or negative sample gives 0.
- R8: On a channel whose received value is ±A plus ±H of trailing interference from the previous bit, with H larger than A, a tap weight of H recovers every transmitted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld_i | input | 1 | Sample strobe; high when `smp_i` holds a new sample |
| smp_i | input | SAMPLE_W | Signed input sample |
| tap_w_i | input | SAMPLE_W | Signed feedback tap weight |
| dec_o | output | 1 | Registered bit decision, also the fed-back previous bit |
| dec_vld_o | output | 1 | High for one cycle after each accepted sample |

## Verification
The bench builds the block with its default 8-bit sample and weight width. At that width the extreme values -128 and +127 are cheap to reach in directed vectors. This exposes the one spot where a narrow negation of the weight would wrap and give the wrong threshold. The 8-bit range also leaves room for a channel model with a signal level of 30 and trailing interference of 40. That model gives received values where a plain sign slicer errs, so a run at zero weight shows the errors and a run at a weight of 40 shows them removed.

// File: rtl/spec_dfe_pkg.sv
package spec_dfe_pkg;

    localparam int unsigned DFE_DEF_W = 8;

    // Pair of tentative decisions, one per assumed previous bit
    typedef struct packed {
        logic if_prev_one;
        logic if_prev_zero;
    } tent_pair_t;

    // Index of each speculative path inside the generate loop
    localparam int unsigned PATH_PREV_ONE  = 0;
    localparam int unsigned PATH_PREV_ZERO = 1;
    localparam int unsigned PATH_COUNT     = 2;

    // Pick the tentative result that matches the previous bit
    function automatic logic pick_path(input tent_pair_t tp, input logic prev);
        return prev ? tp.if_prev_one : tp.if_prev_zero;
    endfunction

endpackage

// File: rtl/dfe_thresh_gen.sv
module dfe_thresh_gen #(
    parameter int unsigned SAMPLE_W = 8,
    localparam int unsigned EXT_W = SAMPLE_W + 1
) (
    input  logic [SAMPLE_W-1:0]   tap_w_i,
    output logic signed [EXT_W-1:0] thr_pos_o,
    output logic signed [EXT_W-1:0] thr_neg_o
);
    logic signed [EXT_W-1:0] w_ext;

    // One extra bit so the negation of the most negative weight is exact
    assign w_ext     = $signed({tap_w_i[SAMPLE_W-1], tap_w_i});
    assign thr_pos_o = w_ext;
    assign thr_neg_o = -w_ext;
endmodule

// File: rtl/dfe_slicer.sv
module dfe_slicer #(
    parameter int unsigned SAMPLE_W = 8,
    localparam int unsigned EXT_W = SAMPLE_W + 1
) (
    input  logic [SAMPLE_W-1:0]     smp_i,
    input  logic signed [EXT_W-1:0] thr_i,
    output logic                    above_o
);
    logic signed [EXT_W-1:0] smp_ext;

    assign smp_ext = $signed({smp_i[SAMPLE_W-1], smp_i});
    assign above_o = (smp_ext > thr_i);
endmodule

// File: rtl/dfe_decide.sv
module dfe_decide
    import spec_dfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take_i,
    input  tent_pair_t tent_i,
    output logic       dec_o,
    output logic       dec_vld_o
);
    logic dec_q;
    logic vld_q;
    logic dec_nxt;

    // The only logic between the flop output and its input: a 2:1 pick
    assign dec_nxt = pick_path(tent_i, dec_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_q <= 1'b0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= take_i;
            if (take_i) begin
                dec_q <= dec_nxt;
            end
        end
    end

    assign dec_o     = dec_q;
    assign dec_vld_o = vld_q;
endmodule

// File: rtl/spec_dfe1.sv
module spec_dfe1
    import spec_dfe_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DFE_DEF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_vld_i,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic [SAMPLE_W-1:0] tap_w_i,
    output logic                dec_o,
    output logic                dec_vld_o
);
    localparam int unsigned EXT_W = SAMPLE_W + 1;

    logic signed [EXT_W-1:0] thr_arr [PATH_COUNT];
    logic [PATH_COUNT-1:0]   above;
    tent_pair_t              tent;

    dfe_thresh_gen #(.SAMPLE_W(SAMPLE_W)) u_thr (
        .tap_w_i   (tap_w_i),
        .thr_pos_o (thr_arr[PATH_PREV_ONE]),
        .thr_neg_o (thr_arr[PATH_PREV_ZERO])
    );

    // Speculative paths, evaluated on every sample
    for (genvar p = 0; p < PATH_COUNT; p++) begin : g_path
        dfe_slicer #(.SAMPLE_W(SAMPLE_W)) u_slc (
            .smp_i   (smp_i),
            .thr_i   (thr_arr[p]),
            .above_o (above[p])
        );
    end

    // Comparator outputs go to the selector with no retiming in between
    assign tent.if_prev_one  = above[PATH_PREV_ONE];
    assign tent.if_prev_zero = above[PATH_PREV_ZERO];

    dfe_decide u_dec (
        .clk       (clk),
        .rst       (rst),
        .take_i    (smp_vld_i),
        .tent_i    (tent),
        .dec_o     (dec_o),
        .dec_vld_o (dec_vld_o)
    );
endmodule

// File: rtl/spec_dfe1_chk.sv
module spec_dfe1_chk #(
    parameter int unsigned SAMPLE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                smp_vld_i,
    input logic [SAMPLE_W-1:0] smp_i,
    input logic [SAMPLE_W-1:0] tap_w_i,
    input logic                dec_o,
    input logic                dec_vld_o
);
    logic signed [SAMPLE_W:0] s_x;
    logic signed [SAMPLE_W:0] w_x;
    logic rst_seen_q = 1'b0;

    assign s_x = $signed({smp_i[SAMPLE_W-1], smp_i});
    assign w_x = $signed({tap_w_i[SAMPLE_W-1], tap_w_i});

    always @(posedge clk) begin
        if (rst_seen_q) begin
            AST_RESET_CLEARS: assert (!dec_o && !dec_vld_o); // R5
        end
        rst_seen_q <= rst;
    end

    AST_PREV_ONE_PATH: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && dec_o) |=> (dec_o == ($past(s_x) > $past(w_x)))); // R1

    AST_PREV_ZERO_PATH: assert property (@(posedge clk) disable iff (rst)
        (smp_vld_i && !dec_o) |=> (dec_o == ($past(s_x) > -$past(w_x)))); // R2

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        smp_vld_i |=> dec_vld_o); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !smp_vld_i |=> ($stable(dec_o) && !dec_vld_o)); // R6
endmodule

bind spec_dfe1 spec_dfe1_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_vld_i (smp_vld_i),
    .smp_i     (smp_i),
    .tap_w_i   (tap_w_i),
    .dec_o     (dec_o),
    .dec_vld_o (dec_vld_o)
);

// File: tb/sim_spec_dfe1.sv
`timescale 1ns/1ps
module sim_spec_dfe1;
    localparam int W = 8;
    localparam int N_VEC = 15;

    // Walked back to back after reset; previous decision starts at 0
    localparam logic signed [W-1:0] T_SMP [N_VEC] = '{
        8'sd5, 8'sd0, -8'sd3, -8'sd10, 8'sd15, -8'sd20, -8'sd19, 8'sd20,
        8'sd127, 8'sd10, 8'sd31, -8'sd29, -8'sd31, 8'sd127, 8'sd127};
    localparam logic signed [W-1:0] T_W [N_VEC] = '{
        8'sd0, 8'sd0, 8'sd0, 8'sd20, 8'sd20, 8'sd20, 8'sd20, 8'sd20,
        -8'sd128, -8'sd30, -8'sd30, -8'sd30, -8'sd30, 8'sd127, 8'sd127};
    localparam bit T_EXP [N_VEC] = '{
        1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0,
        1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam string T_REQ [N_VEC] = '{
        "R7", "R7", "R7", "R2", "R1 R3", "R2", "R2", "R1",
        "R2", "R2", "R2", "R1", "R1", "R2", "R1"};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_vld_i = 1'b0;
    logic [W-1:0] smp_i = '0;
    logic [W-1:0] tap_w_i = '0;
    logic dec_o;
    logic dec_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spec_dfe1 #(.SAMPLE_W(W)) u0 (
        .clk(clk), .rst(rst), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
        .tap_w_i(tap_w_i), .dec_o(dec_o), .dec_vld_o(dec_vld_o));

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic feed(input logic [W-1:0] s, input logic [W-1:0] w);
        smp_i = s; tap_w_i = w; smp_vld_i = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; smp_vld_i = 1'b0;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    // Channel: +-A for the current bit plus +-H from the previous bit
    task automatic run_channel(input logic [W-1:0] w, output int bad);
        logic [15:0] lfsr = 16'hACE1;
        logic prev = 1'b0;
        bad = 0;
        do_reset();
        for (int k = 0; k < 200; k++) begin
            logic bit_k;
            int y;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            bit_k = lfsr[0];
            y = (bit_k ? 30 : -30) + (prev ? 40 : -40);
            feed(W'(y), w);
            if (dec_o !== bit_k) bad++;
            prev = bit_k;
        end
        smp_vld_i = 1'b0;
    endtask

    initial begin
        int bad_eq;
        int bad_raw;
        @(negedge clk); @(negedge clk);
        chk("R5 reset dec_o", dec_o, 1'b0);
        chk("R5 reset dec_vld_o", dec_vld_o, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 no strobe after reset", dec_vld_o, 1'b0);

        for (int i = 0; i < N_VEC; i++) begin
            feed(T_SMP[i], T_W[i]);
            chk({T_REQ[i], " vector"}, dec_o, T_EXP[i]);
            chk("R4 strobe with decision", dec_vld_o, 1'b1);
        end

        // Leave dec_o at 1, then idle with inputs that would flip it
        feed(8'sd50, 8'sd0);
        chk("R7 positive sample", dec_o, 1'b1);
        smp_vld_i = 1'b0; smp_i = 8'h80; tap_w_i = 8'd100;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R6 idle hold dec_o", dec_o, 1'b1);
            chk("R6 idle strobe low", dec_vld_o, 1'b0);
        end

        // Same sample and weight, different previous bit (R3)
        feed(8'sd5, 8'sd10);
        chk("R3 prev=1 path", dec_o, 1'b0);
        feed(8'sd5, 8'sd10);
        chk("R3 prev=0 path", dec_o, 1'b1);

        // Reset in the middle of a stream
        rst = 1'b1;
        @(negedge clk);
        chk("R5 mid-stream reset dec_o", dec_o, 1'b0);
        chk("R5 mid-stream reset dec_vld_o", dec_vld_o, 1'b0);
        rst = 1'b0; smp_vld_i = 1'b0;

        run_channel(8'd0, bad_raw);
        checks++;
        if (bad_raw == 0) begin
            errors++;
            $display("FAIL R8 unequalized errors actual=%0d expected=>0", bad_raw);
        end
        run_channel(8'd40, bad_eq);
        checks++;
        if (bad_eq != 0) begin
            errors++;
            $display("FAIL R8 equalized errors actual=%0d expected=0", bad_eq);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule